// File: doc/BRIEF.md
# Requester ID Translation Table

The block translates a 16-bit requester ID into a 12-bit virtual ID and a 2-bit access type. It does this with a table of programmable entries. Each entry holds an enable bit, a 16-bit compare value, a 16-bit bit-select mask, and a result pair. An entry fires when it is enabled and the requester ID, ANDed with the entry mask, equals the compare value. Every enabled entry is tested in parallel. The hit with the lowest entry number supplies the result. When no entry fires, a programmable default pair is returned instead.

Two independent lookup ports share one table: one port for read requests and one for write requests. Both ports may be active in the same cycle. Each port returns its result one cycle after its valid strobe, together with a hit flag and the index of the winning entry. A flat write port programs the entries and the default pair. A combinational read port returns the stored fields.

Top module: `rid_xlate_table`

## Requirements
- R1: After reset, every enable bit and every stored field reads as zero, and any lookup returns ID 0, type 0, hit 0 and index 0.
- R2: An entry fires for a requester ID exactly when its enable bit is 1 and (ID AND mask) equals its compare value.
- R3: A disabled entry never fires, whatever its compare value and mask hold.
- R4: When several entries fire, the result ID and type come from the lowest-numbered firing entry.
- R5: When no entry fires, the result is the default ID and default type, with hit flag 0 and index 0.
- R6: A result with its valid flag appears exactly one cycle after a port's valid input is high. The result valid flag is 0 in the cycle after the valid input is low.
- R7: The read-channel and write-channel ports look up different IDs in the same cycle against the same table, and each returns its own correct result.
- R8: A configuration write changes lookups that start in the cycle after the write. A lookup in the same cycle as the write still sees the old contents.
- R9: Register address = {entry index, 2-bit field}. Field 0 is the control register, with the enable in bit 0. Field 1 is the key register: compare value in bits 15:0, mask in bits 31:16. Field 2 is the result register: ID in bits 11:0, type in bits 17:16. Field 3, at any index, is the default pair in the same layout as field 2. Read data returns the stored fields, and all other bits read as zero.
- R10: On a hit, the hit flag is 1 and the index output equals the number of the winning entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | {entry index, field select} |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| rd_valid | input | 1 | Read-channel lookup request |
| rd_reqid | input | 16 | Read-channel requester ID |
| rd_res_valid | output | 1 | Read-channel result valid |
| rd_res_hit | output | 1 | Read-channel: an entry fired |
| rd_res_idx | output | 5 | Read-channel winning entry |
| rd_res_vid | output | 12 | Read-channel virtual ID |
| rd_res_type | output | 2 | Read-channel access type |
| wr_valid | input | 1 | Write-channel lookup request |
| wr_reqid | input | 16 | Write-channel requester ID |
| wr_res_valid | output | 1 | Write-channel result valid |
| wr_res_hit | output | 1 | Write-channel: an entry fired |
| wr_res_idx | output | 5 | Write-channel winning entry |
| wr_res_vid | output | 12 | Write-channel virtual ID |
| wr_res_type | output | 2 | Write-channel access type |

## Verification
Two events can fall in the same cycle:
- a configuration write and a lookup on either port;
- lookups on both ports.

The bench enables an entry in the same cycle as a lookup whose ID matches that entry. It expects the default result first, and the entry's result from the next lookup on. Throughout the table sweeps, both ports are driven in every cycle with different IDs. Each port is judged against a bench model that scans the entries upward from index 0 with an early-exit flag.

// File: rtl/rxt_pkg.sv
`timescale 1ns/1ps
package rxt_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_KEY  = 2'd1,
    FLD_RES  = 2'd2,
    FLD_DFLT = 2'd3
  } field_e;

  localparam int CFG_DATA_W = 32;
  localparam int TYPE_LSB   = 16;
  localparam int FLD_W      = 2;
endpackage

// File: rtl/rxt_regfile.sv
`timescale 1ns/1ps
module rxt_regfile #(
  parameter int N_ENTRIES = 32,
  parameter int ID_W      = 16,
  parameter int VID_W     = 12,
  parameter int TYPE_W    = 2,
  parameter int IDX_W     = 5,
  parameter int ADDR_W    = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr_en,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [rxt_pkg::CFG_DATA_W-1:0]    cfg_wdata,
  output logic [rxt_pkg::CFG_DATA_W-1:0]    cfg_rdata,
  output logic [N_ENTRIES-1:0]              en_vec,
  output logic [N_ENTRIES-1:0][ID_W-1:0]    match_tab,
  output logic [N_ENTRIES-1:0][ID_W-1:0]    mask_tab,
  output logic [N_ENTRIES-1:0][VID_W-1:0]   vid_tab,
  output logic [N_ENTRIES-1:0][TYPE_W-1:0]  type_tab,
  output logic [VID_W-1:0]                  dflt_vid,
  output logic [TYPE_W-1:0]                 dflt_type
);
  import rxt_pkg::*;

  localparam int KEY_W = 2 * ID_W;

  field_e             fld;
  logic [IDX_W-1:0]   sel_idx;
  logic               unused_wdata;

  assign fld          = field_e'(cfg_addr[FLD_W-1:0]);
  assign sel_idx      = cfg_addr[ADDR_W-1:FLD_W];
  assign unused_wdata = ^cfg_wdata;

  // Per-entry storage
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic              hit_this;
    logic              en_q;
    logic [ID_W-1:0]   match_q;
    logic [ID_W-1:0]   mask_q;
    logic [VID_W-1:0]  vid_q;
    logic [TYPE_W-1:0] type_q;

    assign hit_this = cfg_wr_en && (sel_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        match_q <= '0;
        mask_q  <= '0;
        vid_q   <= '0;
        type_q  <= '0;
      end else if (hit_this) begin
        case (fld)
          FLD_CTRL: en_q <= cfg_wdata[0];
          FLD_KEY: begin
            match_q <= cfg_wdata[ID_W-1:0];
            mask_q  <= cfg_wdata[KEY_W-1:ID_W];
          end
          FLD_RES: begin
            vid_q  <= cfg_wdata[VID_W-1:0];
            type_q <= cfg_wdata[TYPE_LSB +: TYPE_W];
          end
          default: ;
        endcase
      end
    end

    assign en_vec[e]    = en_q;
    assign match_tab[e] = match_q;
    assign mask_tab[e]  = mask_q;
    assign vid_tab[e]   = vid_q;
    assign type_tab[e]  = type_q;
  end

  // Default pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_vid  <= '0;
      dflt_type <= '0;
    end else if (cfg_wr_en && fld == FLD_DFLT) begin
      dflt_vid  <= cfg_wdata[VID_W-1:0];
      dflt_type <= cfg_wdata[TYPE_LSB +: TYPE_W];
    end
  end

  function automatic logic [CFG_DATA_W-1:0] pack_result(
    input logic [VID_W-1:0] v, input logic [TYPE_W-1:0] t);
    logic [CFG_DATA_W-1:0] w;
    w = '0;
    w[VID_W-1:0]         = v;
    w[TYPE_LSB +: TYPE_W] = t;
    return w;
  endfunction

  // Read mux
  always_comb begin
    cfg_rdata = '0;
    if (fld == FLD_DFLT) begin
      cfg_rdata = pack_result(dflt_vid, dflt_type);
    end else if (int'(sel_idx) < N_ENTRIES) begin
      case (fld)
        FLD_CTRL: cfg_rdata[0] = en_vec[sel_idx];
        FLD_KEY:  cfg_rdata[KEY_W-1:0] = {mask_tab[sel_idx], match_tab[sel_idx]};
        FLD_RES:  cfg_rdata = pack_result(vid_tab[sel_idx], type_tab[sel_idx]);
        default:  cfg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxt_match.sv
`timescale 1ns/1ps
module rxt_match #(
  parameter int N_ENTRIES = 32,
  parameter int ID_W      = 16,
  parameter int VID_W     = 12,
  parameter int TYPE_W    = 2,
  parameter int IDX_W     = 5
) (
  input  logic [ID_W-1:0]                   reqid,
  input  logic [N_ENTRIES-1:0]              en_vec,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]    match_tab,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]    mask_tab,
  input  logic [N_ENTRIES-1:0][VID_W-1:0]   vid_tab,
  input  logic [N_ENTRIES-1:0][TYPE_W-1:0]  type_tab,
  input  logic [VID_W-1:0]                  dflt_vid,
  input  logic [TYPE_W-1:0]                 dflt_type,
  output logic [N_ENTRIES-1:0]              hit_vec,
  output logic [N_ENTRIES-1:0]              sel_oh,
  output logic                              any_hit,
  output logic [IDX_W-1:0]                  hit_idx,
  output logic [VID_W-1:0]                  res_vid,
  output logic [TYPE_W-1:0]                 res_type
);
  function automatic logic entry_fires(
    input logic en, input logic [ID_W-1:0] id,
    input logic [ID_W-1:0] cmp, input logic [ID_W-1:0] msk);
    return en && ((id & msk) == cmp);
  endfunction

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = entry_fires(en_vec[e], reqid, match_tab[e], mask_tab[e]);
  end

  // Lowest index wins: scan downward, last write is the lowest hit
  always_comb begin
    sel_oh  = '0;
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        hit_idx   = IDX_W'(i);
        any_hit   = 1'b1;
      end
    end
  end

  // One-hot AND-OR result select with default fallback
  always_comb begin
    logic [VID_W-1:0]  v;
    logic [TYPE_W-1:0] t;
    v = '0;
    t = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      v = v | ({VID_W{sel_oh[i]}} & vid_tab[i]);
      t = t | ({TYPE_W{sel_oh[i]}} & type_tab[i]);
    end
    res_vid  = any_hit ? v : dflt_vid;
    res_type = any_hit ? t : dflt_type;
  end
endmodule

// File: rtl/rxt_result_reg.sv
`timescale 1ns/1ps
module rxt_result_reg #(
  parameter int VID_W  = 12,
  parameter int TYPE_W = 2,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [VID_W-1:0]  in_vid,
  input  logic [TYPE_W-1:0] in_type,
  output logic              out_valid,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx,
  output logic [VID_W-1:0]  out_vid,
  output logic [TYPE_W-1:0] out_type
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_vid   <= '0;
      out_type  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= in_hit;
        out_idx  <= in_idx;
        out_vid  <= in_vid;
        out_type <= in_type;
      end
    end
  end
endmodule

// File: rtl/rid_xlate_table.sv
`timescale 1ns/1ps
module rid_xlate_table #(
  parameter int N_ENTRIES = 32,
  parameter int ID_W      = 16,
  parameter int VID_W     = 12,
  parameter int TYPE_W    = 2,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int ADDR_W   = IDX_W + rxt_pkg::FLD_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr_en,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [rxt_pkg::CFG_DATA_W-1:0] cfg_wdata,
  output logic [rxt_pkg::CFG_DATA_W-1:0] cfg_rdata,
  input  logic                           rd_valid,
  input  logic [ID_W-1:0]                rd_reqid,
  output logic                           rd_res_valid,
  output logic                           rd_res_hit,
  output logic [IDX_W-1:0]               rd_res_idx,
  output logic [VID_W-1:0]               rd_res_vid,
  output logic [TYPE_W-1:0]              rd_res_type,
  input  logic                           wr_valid,
  input  logic [ID_W-1:0]                wr_reqid,
  output logic                           wr_res_valid,
  output logic                           wr_res_hit,
  output logic [IDX_W-1:0]               wr_res_idx,
  output logic [VID_W-1:0]               wr_res_vid,
  output logic [TYPE_W-1:0]              wr_res_type
);
  // Shared table contents
  logic [N_ENTRIES-1:0]             en_vec;
  logic [N_ENTRIES-1:0][ID_W-1:0]   match_tab;
  logic [N_ENTRIES-1:0][ID_W-1:0]   mask_tab;
  logic [N_ENTRIES-1:0][VID_W-1:0]  vid_tab;
  logic [N_ENTRIES-1:0][TYPE_W-1:0] type_tab;
  logic [VID_W-1:0]                 dflt_vid;
  logic [TYPE_W-1:0]                dflt_type;

  // Per-port internal events, named for the checker
  logic [N_ENTRIES-1:0] rd_hit_vec, rd_sel_oh, wr_hit_vec, wr_sel_oh;
  logic                 rd_any_hit, wr_any_hit;
  logic [IDX_W-1:0]     rd_idx_c, wr_idx_c;
  logic [VID_W-1:0]     rd_vid_c, wr_vid_c;
  logic [TYPE_W-1:0]    rd_type_c, wr_type_c;

  rxt_regfile #(
    .N_ENTRIES(N_ENTRIES), .ID_W(ID_W), .VID_W(VID_W), .TYPE_W(TYPE_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en_vec(en_vec),
    .match_tab(match_tab), .mask_tab(mask_tab), .vid_tab(vid_tab),
    .type_tab(type_tab), .dflt_vid(dflt_vid), .dflt_type(dflt_type)
  );

  rxt_match #(
    .N_ENTRIES(N_ENTRIES), .ID_W(ID_W), .VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)
  ) u_rd_match (
    .reqid(rd_reqid), .en_vec(en_vec), .match_tab(match_tab), .mask_tab(mask_tab),
    .vid_tab(vid_tab), .type_tab(type_tab), .dflt_vid(dflt_vid), .dflt_type(dflt_type),
    .hit_vec(rd_hit_vec), .sel_oh(rd_sel_oh), .any_hit(rd_any_hit),
    .hit_idx(rd_idx_c), .res_vid(rd_vid_c), .res_type(rd_type_c)
  );

  rxt_match #(
    .N_ENTRIES(N_ENTRIES), .ID_W(ID_W), .VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)
  ) u_wr_match (
    .reqid(wr_reqid), .en_vec(en_vec), .match_tab(match_tab), .mask_tab(mask_tab),
    .vid_tab(vid_tab), .type_tab(type_tab), .dflt_vid(dflt_vid), .dflt_type(dflt_type),
    .hit_vec(wr_hit_vec), .sel_oh(wr_sel_oh), .any_hit(wr_any_hit),
    .hit_idx(wr_idx_c), .res_vid(wr_vid_c), .res_type(wr_type_c)
  );

  rxt_result_reg #(.VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_rd_out (
    .clk(clk), .rst_n(rst_n), .in_valid(rd_valid), .in_hit(rd_any_hit),
    .in_idx(rd_idx_c), .in_vid(rd_vid_c), .in_type(rd_type_c),
    .out_valid(rd_res_valid), .out_hit(rd_res_hit), .out_idx(rd_res_idx),
    .out_vid(rd_res_vid), .out_type(rd_res_type)
  );

  rxt_result_reg #(.VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)) u_wr_out (
    .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .in_hit(wr_any_hit),
    .in_idx(wr_idx_c), .in_vid(wr_vid_c), .in_type(wr_type_c),
    .out_valid(wr_res_valid), .out_hit(wr_res_hit), .out_idx(wr_res_idx),
    .out_vid(wr_res_vid), .out_type(wr_res_type)
  );
endmodule

// File: rtl/rxt_checker.sv
`timescale 1ns/1ps
module rxt_checker #(
  parameter int N_ENTRIES = 32,
  parameter int VID_W     = 12,
  parameter int TYPE_W    = 2,
  parameter int IDX_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_ENTRIES-1:0] en_vec,
  input logic [VID_W-1:0]     dflt_vid,
  input logic [TYPE_W-1:0]    dflt_type,
  input logic                 rd_valid,
  input logic [N_ENTRIES-1:0] rd_hit_vec,
  input logic [N_ENTRIES-1:0] rd_sel_oh,
  input logic                 rd_any_hit,
  input logic                 rd_res_valid,
  input logic                 rd_res_hit,
  input logic [IDX_W-1:0]     rd_res_idx,
  input logic [VID_W-1:0]     rd_res_vid,
  input logic [TYPE_W-1:0]    rd_res_type,
  input logic                 wr_valid,
  input logic [N_ENTRIES-1:0] wr_hit_vec,
  input logic [N_ENTRIES-1:0] wr_sel_oh,
  input logic                 wr_any_hit,
  input logic                 wr_res_valid,
  input logic                 wr_res_hit,
  input logic [IDX_W-1:0]     wr_res_idx,
  input logic [VID_W-1:0]     wr_res_vid,
  input logic [TYPE_W-1:0]    wr_res_type
);
  logic [N_ENTRIES-1:0] en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_vec;
  end

  // R3: the comparator vector never flags a disabled entry
  p_no_disabled_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_hit_vec | wr_hit_vec) & ~en_vec) == '0);

  // R3: a reported winner was enabled when the lookup was taken
  p_winner_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res_valid && rd_res_hit) |-> en_q[rd_res_idx]);
  p_winner_enabled_w_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_res_valid && wr_res_hit) |-> en_q[wr_res_idx]);

  // R4: at most one selected entry, and it is among the hits
  p_single_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_sel_oh) && $onehot0(wr_sel_oh));
  p_sel_in_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_sel_oh & ~rd_hit_vec) | (wr_sel_oh & ~wr_hit_vec)) == '0);

  // R4: no hit below the selected entry
  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any_hit |-> (((rd_sel_oh - 1'b1) & rd_hit_vec) == '0));
  p_lowest_wins_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any_hit |-> (((wr_sel_oh - 1'b1) & wr_hit_vec) == '0));

  // R5: a miss returns the default pair that was stored at lookup time
  p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_any_hit) |=>
      (!rd_res_hit && rd_res_vid == $past(dflt_vid) && rd_res_type == $past(dflt_type)));
  p_miss_default_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_any_hit) |=>
      (!wr_res_hit && wr_res_vid == $past(dflt_vid) && wr_res_type == $past(dflt_type)));

  // R6: result valid follows the request one cycle later
  p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_res_valid);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_res_valid);
  p_valid_latency_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> wr_res_valid);
  p_idle_quiet_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !wr_res_valid);
endmodule

bind rid_xlate_table rxt_checker #(
  .N_ENTRIES(N_ENTRIES), .VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W)
) u_rxt_checker (
  .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .dflt_vid(dflt_vid), .dflt_type(dflt_type),
  .rd_valid(rd_valid), .rd_hit_vec(rd_hit_vec), .rd_sel_oh(rd_sel_oh),
  .rd_any_hit(rd_any_hit), .rd_res_valid(rd_res_valid), .rd_res_hit(rd_res_hit),
  .rd_res_idx(rd_res_idx), .rd_res_vid(rd_res_vid), .rd_res_type(rd_res_type),
  .wr_valid(wr_valid), .wr_hit_vec(wr_hit_vec), .wr_sel_oh(wr_sel_oh),
  .wr_any_hit(wr_any_hit), .wr_res_valid(wr_res_valid), .wr_res_hit(wr_res_hit),
  .wr_res_idx(wr_res_idx), .wr_res_vid(wr_res_vid), .wr_res_type(wr_res_type)
);

// File: tb/test_rid_xlate_table.sv
`timescale 1ns/1ps
module test_rid_xlate_table;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_valid = 1'b0, wr_valid = 1'b0;
  logic [15:0] rd_reqid = '0, wr_reqid = '0;
  logic        rd_res_valid, rd_res_hit, wr_res_valid, wr_res_hit;
  logic [4:0]  rd_res_idx, wr_res_idx;
  logic [11:0] rd_res_vid, wr_res_vid;
  logic [1:0]  rd_res_type, wr_res_type;

  always #10 clk = ~clk;

  rid_xlate_table i_rid_xlate_table (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_valid(rd_valid), .rd_reqid(rd_reqid), .rd_res_valid(rd_res_valid),
    .rd_res_hit(rd_res_hit), .rd_res_idx(rd_res_idx), .rd_res_vid(rd_res_vid),
    .rd_res_type(rd_res_type),
    .wr_valid(wr_valid), .wr_reqid(wr_reqid), .wr_res_valid(wr_res_valid),
    .wr_res_hit(wr_res_hit), .wr_res_idx(wr_res_idx), .wr_res_vid(wr_res_vid),
    .wr_res_type(wr_res_type)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the table
  logic        m_en    [N];
  logic [15:0] m_match [N];
  logic [15:0] m_mask  [N];
  logic [11:0] m_vid   [N];
  logic [1:0]  m_typ   [N];
  logic [11:0] m_dvid;
  logic [1:0]  m_dtyp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Upward scan with early exit: first enabled match wins
  function automatic logic [20:0] model_lookup(input logic [15:0] id);
    logic found;
    logic [20:0] r;
    found = 1'b0;
    r = {1'b1, 1'b0, 5'd0, m_dvid, m_dtyp};
    for (int i = 0; i < N; i++) begin
      if (!found && m_en[i] && ((id & m_mask[i]) == m_match[i])) begin
        found = 1'b1;
        r = {1'b1, 1'b1, 5'(i), m_vid[i], m_typ[i]};
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] model_reg(input int idx, input logic [1:0] fld);
    case (fld)
      2'd0: return {31'd0, m_en[idx]};
      2'd1: return {m_mask[idx], m_match[idx]};
      2'd2: return {14'd0, m_typ[idx], 4'd0, m_vid[idx]};
      default: return {14'd0, m_dtyp, 4'd0, m_dvid};
    endcase
  endfunction

  task automatic model_write(input int idx, input logic [1:0] fld, input logic [31:0] d);
    case (fld)
      2'd0: m_en[idx] = d[0];
      2'd1: begin m_match[idx] = d[15:0]; m_mask[idx] = d[31:16]; end
      2'd2: begin m_vid[idx] = d[11:0]; m_typ[idx] = d[17:16]; end
      default: begin m_dvid = d[11:0]; m_dtyp = d[17:16]; end
    endcase
  endtask

  // Called at a falling edge; returns at a falling edge
  task automatic cfg_wr(input int idx, input logic [1:0] fld, input logic [31:0] d);
    cfg_wr_en = 1'b1;
    cfg_addr  = {5'(idx), fld};
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(idx, fld, d);
  endtask

  task automatic cfg_rd_chk(input int idx, input logic [1:0] fld, input string req);
    cfg_addr = {5'(idx), fld};
    #1;
    chk(req, cfg_rdata, model_reg(idx, fld));
    @(negedge clk);
  endtask

  task automatic look2(input logic [15:0] a, input bit va, input logic [15:0] b,
                       input bit vb, input string req);
    logic [20:0] ea, eb;
    ea = model_lookup(a);
    eb = model_lookup(b);
    rd_valid = va; rd_reqid = a;
    wr_valid = vb; wr_reqid = b;
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
    if (va) chk({req, " rd"}, 32'({rd_res_valid, rd_res_hit, rd_res_idx, rd_res_vid, rd_res_type}), 32'(ea));
    else    chk("R6 rd idle", 32'(rd_res_valid), 32'd0);
    if (vb) chk({req, " wr"}, 32'({wr_res_valid, wr_res_hit, wr_res_idx, wr_res_vid, wr_res_type}), 32'(eb));
    else    chk("R6 wr idle", 32'(wr_res_valid), 32'd0);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++)
      look2(m_match[i], 1'b1, m_match[(i * 7) % N] ^ 16'h0001, 1'b1, req);
    for (int j = 0; j < 64; j++)
      look2(16'(j * 1031), 1'b1, 16'(16'hFFFF - j * 977), 1'b1, req);
  endtask

  task automatic readback_all(input string req);
    for (int i = 0; i < N; i++)
      for (int f = 0; f < 3; f++) cfg_rd_chk(i, 2'(f), req);
    cfg_rd_chk(0, 2'd3, req);
    cfg_rd_chk(17, 2'd3, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [20:0] e_old;
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_match[i] = '0; m_mask[i] = '0; m_vid[i] = '0; m_typ[i] = '0;
    end
    m_dvid = '0; m_dtyp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 res_valid after reset", 32'({rd_res_valid, wr_res_valid}), 32'd0);
    readback_all("R1 reset readback");
    look2(16'h0000, 1'b1, 16'hFFFF, 1'b1, "R1 lookup after reset");
    look2(16'h1234, 1'b1, 16'h8001, 1'b1, "R1 lookup after reset");

    // R5: default pair on miss
    cfg_wr(9, 2'd3, 32'h0001_0ABC);
    look2(16'h4321, 1'b1, 16'h0000, 1'b1, "R5 default on miss");
    cfg_rd_chk(3, 2'd3, "R9 default readback");

    // Program all entries, none enabled; junk in unused bits
    for (int i = 0; i < N; i++) begin
      logic [15:0] mk;
      mk = 16'hFFFF >> (i / 2);
      cfg_wr(i, 2'd1, {mk, 16'(16'h1234 * (i + 1)) & mk});
      cfg_wr(i, 2'd2, 32'hFFFC_F000 | {14'd0, 2'(i % 4), 4'd0, 12'(i * 113 + 5)});
      cfg_wr(i, 2'd0, 32'hFFFF_FFFE);
    end
    readback_all("R9 field readback");
    sweep("R3 disabled entries miss");

    // R8: enable entry 0 in the same cycle as a lookup that matches it
    e_old = model_lookup(m_match[0]);
    cfg_wr_en = 1'b1; cfg_addr = {5'd0, 2'd0}; cfg_wdata = 32'd1;
    rd_valid = 1'b1; rd_reqid = m_match[0];
    @(negedge clk);
    cfg_wr_en = 1'b0; rd_valid = 1'b0;
    model_write(0, 2'd0, 32'd1);
    chk("R8 same-cycle lookup sees old", 32'({rd_res_valid, rd_res_hit, rd_res_idx, rd_res_vid, rd_res_type}), 32'(e_old));
    look2(m_match[0], 1'b1, m_match[0], 1'b1, "R8 next lookup sees new");
    chk("R10 entry 0 index", 32'({rd_res_hit, rd_res_idx}), {26'd0, 1'b1, 5'd0});

    // Even entries enabled
    for (int i = 2; i < N; i += 2) cfg_wr(i, 2'd0, 32'd1);
    sweep("R2 R4 R7 R10 even entries");

    // All entries enabled
    for (int i = 1; i < N; i += 2) cfg_wr(i, 2'd0, 32'd1);
    sweep("R2 R4 R7 R10 all entries");
    cfg_rd_chk(31, 2'd0, "R9 enable readback");

    // R4: entry 31 (mask 1, match 0) and entry 30 both match an even ID
    look2(m_match[30], 1'b1, 16'h0002, 1'b1, "R4 lowest wins");

    // R6: idle cycles
    look2(16'h1234, 1'b0, 16'h1234, 1'b0, "R6 idle");
    look2(16'h1234, 1'b1, 16'h1234, 1'b0, "R6 one port idle");

    // R3: disabling entry 0 sends its ID to the next match
    cfg_wr(0, 2'd0, 32'd0);
    look2(m_match[0], 1'b1, m_match[1], 1'b1, "R3 disabled entry skipped");
    sweep("R3 R4 entry 0 off");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule